// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is a single timer channel that measures the time between valid edges on an input pin. A counter advances on each count-clock enable pulse from an outside prescaler. At every valid edge, three things happen in one cycle. The running count is copied into a capture register, the counter restarts from zero, and a one-cycle interrupt pulse is raised. Software reads the capture register to get the latest interval.

Control is through a small register port. Software writes self-clearing start and stop trigger bits, and sets a mode register. The mode register picks which edge counts and whether an interrupt is raised when counting begins. A status register holds an overflow flag, which is rewritten at every capture to say whether the counter wrapped during that interval. The input pin passes through a two-stage synchroniser before edge detection. The edge choice may be changed while the channel runs. A unit-enable input returns the whole channel to its idle, zeroed state when it is low.

Top module: `pulse_interval_timer`

## Requirements
- R1: A write to address 0 with bit 0 set starts the channel. Bit 2 of address 0 then reads 1 (running). Bits 1:0 of address 0 always read 0, because the trigger bits are not stored.
- R2: On the first count-clock tick after start, the counter (address 3) is cleared to 0. After that it rises by one per tick. Without a tick it holds its value.
- R3: If mode bit 2 (start interrupt) is 1, an interrupt pulse is raised on that first clearing tick. If the bit is 0, no pulse is raised at start.
- R4: A valid edge while running does three things in one cycle: it copies the counter into the capture register (address 4), clears the counter to 0, and raises `irq` for exactly one cycle.
- R5: Mode bits 1:0 select the valid edge: 00 falling, 01 rising, 10 or 11 both. An edge that is not selected causes no capture and no interrupt.
- R6: At each capture, status bit 0 (address 2) becomes 1 if the counter rolled from all-ones to zero since the previous capture or start, and 0 otherwise.
- R7: A write to address 0 with bit 1 set stops the channel. Bit 2 of address 0 then reads 0. The counter and the overflow flag hold their values, and input edges are ignored. Stop wins over start in the same write.
- R8: Mode writes (address 1) update bits 2:0 while stopped. While running, only bits 1:0 change and bit 2 keeps its value.
- R9: If a valid edge and a count-clock tick fall in the same cycle, the capture wins and the counter is cleared, not incremented.
- R10: Asynchronous reset, or `unit_en` low, clears the counter, capture, status, mode and running state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_en | input | 1 | Unit enable; low holds the channel cleared |
| tick | input | 1 | Count-clock enable pulse from the prescaler |
| pin_in | input | 1 | Measured input pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume a few things about the inputs: `unit_en` is steady for at least one cycle around each write, and a start is followed by a tick before the first valid edge, so that no capture sees a counter that was never cleared. The stimulus holds `tick` high throughout, apart from one deliberate pause. It also spaces pin toggles many cycles after each start. Each expected capture value can then be worked out from the cycle numbers at which the writes and pin changes were driven.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_MODE  = 3'd1,
        A_STAT  = 3'd2,
        A_COUNT = 3'd3,
        A_CAPT  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_FALL  = 2'b00,
        EDGE_RISE  = 2'b01,
        EDGE_BOTH  = 2'b10,
        EDGE_BOTHX = 2'b11
    } edge_sel_e;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_STOP_BIT  = 1;
    localparam int CTRL_RUN_BIT   = 2;
    localparam int MODE_SIRQ_BIT  = 2;
endpackage

// File: rtl/pit_sync_edge.sv
module pit_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       hit
);
    import pit_pkg::*;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
    } st_t;

    st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[SYNC_STAGES-2:0], pin};
        st_d.prev = st_q.sh[SYNC_STAGES-1];
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sh[SYNC_STAGES-1] & ~st_q.prev;
    assign fall = ~st_q.sh[SYNC_STAGES-1] & st_q.prev;

    always_comb begin
        unique case (edge_sel_e'(sel))
            EDGE_FALL: hit = fall;
            EDGE_RISE: hit = rise;
            default:   hit = rise | fall;
        endcase
    end
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  logic       stop,
    input  logic       mode_wr,
    input  logic [2:0] mode_data,
    input  logic       tick,
    input  logic       hit,
    output logic       run,
    output logic       pending,
    output logic       arm,
    output logic [1:0] edge_sel,
    output logic       sirq
);
    import pit_pkg::*;

    typedef struct packed {
        logic       run;
        logic       pending;
        logic [1:0] edge_sel;
        logic       sirq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.run && (tick || hit)) st_d.pending = 1'b0;
        if (mode_wr) begin
            st_d.edge_sel = mode_data[1:0];
            if (!st_q.run) st_d.sirq = mode_data[MODE_SIRQ_BIT];
        end
        if (stop) begin
            st_d.run     = 1'b0;
            st_d.pending = 1'b0;
        end else if (start) begin
            st_d.run     = 1'b1;
            st_d.pending = 1'b1;
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run      = st_q.run;
    assign pending  = st_q.pending;
    assign arm      = start & ~stop;
    assign edge_sel = st_q.edge_sel;
    assign sirq     = st_q.sirq;
endmodule

// File: rtl/pit_core.sv
module pit_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             pending,
    input  logic             arm,
    input  logic             sirq,
    input  logic             tick,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             ovf,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             ovf;
        logic             wrap;
        logic             irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (arm) st_d.wrap = 1'b0;
        if (run) begin
            if (hit) begin
                st_d.cap  = st_q.cnt;
                st_d.cnt  = '0;
                st_d.ovf  = st_q.wrap;
                st_d.wrap = 1'b0;
                st_d.irq  = 1'b1;
            end else if (tick) begin
                if (pending) begin
                    st_d.cnt = '0;
                    st_d.irq = sirq;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_MAX) st_d.wrap = 1'b1;
                end
            end
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign cap = st_q.cap;
    assign ovf = st_q.ovf;
    assign irq = st_q.irq;
endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_en,
    input  logic             tick,
    input  logic             pin_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    import pit_pkg::*;

    logic             clr;
    logic             start_wr, stop_wr, mode_wr;
    logic             hit, run, pending, arm, sirq, ovf;
    logic [1:0]       edge_sel;
    logic [CNT_W-1:0] cnt, cap;
    logic             unused_wdata;

    assign clr          = ~unit_en;
    assign start_wr     = wr_en && (reg_addr_e'(wr_addr) == A_CTRL) && wr_data[CTRL_START_BIT];
    assign stop_wr      = wr_en && (reg_addr_e'(wr_addr) == A_CTRL) && wr_data[CTRL_STOP_BIT];
    assign mode_wr      = wr_en && (reg_addr_e'(wr_addr) == A_MODE);
    assign unused_wdata = ^wr_data[CNT_W-1:3];

    pit_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pin(pin_in), .sel(edge_sel), .hit(hit)
    );

    pit_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start_wr), .stop(stop_wr),
        .mode_wr(mode_wr), .mode_data(wr_data[2:0]), .tick(tick), .hit(hit),
        .run(run), .pending(pending), .arm(arm), .edge_sel(edge_sel), .sirq(sirq)
    );

    pit_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .pending(pending),
        .arm(arm), .sirq(sirq), .tick(tick), .hit(hit),
        .cnt(cnt), .cap(cap), .ovf(ovf), .irq(irq)
    );

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            A_CTRL:  rd_data[CTRL_RUN_BIT] = run;
            A_MODE:  rd_data[2:0] = {sirq, edge_sel};
            A_STAT:  rd_data[0] = ovf;
            A_COUNT: rd_data = cnt;
            A_CAPT:  rd_data = cap;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pit_chk.sv
module pit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unit_en,
    input logic             tick,
    input logic             start_wr,
    input logic             stop_wr,
    input logic             hit,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap,
    input logic             ovf,
    input logic             irq
);
    // R1
    start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !stop_wr && unit_en) |=> run);

    // R7
    stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && unit_en) |=> !run);

    // R7
    idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && unit_en) |=> $stable(cnt));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !hit && unit_en) |=> $stable(cnt));

    // R4
    capture_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hit && unit_en) |=> (irq && cnt == '0));

    // R9
    capture_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hit && tick && unit_en) |=> (cnt == '0));

    // R4
    cap_only_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(unit_en) && !$stable(cap)) |-> irq);

    // R6
    ovf_only_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(unit_en) && !$stable(ovf)) |-> irq);

    // R10
    unit_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (cnt == '0 && cap == '0 && !run && !ovf));
endmodule

bind pulse_interval_timer pit_chk #(.CNT_W(CNT_W)) u_pit_chk (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .tick(tick),
    .start_wr(start_wr), .stop_wr(stop_wr), .hit(hit), .run(run),
    .cnt(cnt), .cap(cap), .ovf(ovf), .irq(irq)
);

// File: tb/test_pulse_interval_timer.sv
module test_pulse_interval_timer;
    localparam int CNT_W = 16;
    localparam int HALF  = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             unit_en = 1'b1;
    logic             tick = 1'b1;
    logic             pin_in = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [2:0]       rd_addr = 3'd4;
    logic [CNT_W-1:0] rd_data;
    logic             irq;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int exp_q[$];

    pulse_interval_timer #(.CNT_W(CNT_W)) i_pulse_interval_timer (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .tick(tick), .pin_in(pin_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    always #HALF clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: every irq pulse cycle consumes one expected item (-1 = start pulse)
    always @(posedge clk) begin
        #2;
        if (rst_n && irq) begin
            if (exp_q.size() == 0) begin
                check(1, 0, "R4/R5 unexpected irq");
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e >= 0) check(int'(rd_data), e, "R4 capture value");
                else        check(1, 1, "R3 start irq");
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d, output int n);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; n = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
        @(negedge clk);
        rd_addr = 3'd4;
    endtask

    task automatic set_pin(input logic v, output int n);
        @(negedge clk);
        pin_in = v; n = cyc;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        #(HALF * 2 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n_w, p, lastp, v, c1, dummy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        rd(3'd0, v); check(v, 0, "R10 reset ctrl");
        rd(3'd1, v); check(v, 0, "R10 reset mode");
        rd(3'd2, v); check(v, 0, "R10 reset status");
        rd(3'd3, v); check(v, 0, "R10 reset count");
        rd(3'd4, v); check(v, 0, "R10 reset capture");

        // rising edge, start irq on; all mode bits writable while stopped (R8)
        wr(3'd1, 16'h0005, dummy);
        rd(3'd1, v); check(v, 5, "R8 mode write stopped");
        exp_q.push_back(-1);
        wr(3'd0, 16'h0001, n_w);
        lastp = n_w - 1;
        idle(3);
        rd(3'd0, v); check(v, 4, "R1 running, triggers read 0");
        @(negedge clk); rd_addr = 3'd3; #1;
        check(int'(rd_data), cyc - n_w - 2, "R2 count after start");
        idle(1); rd_addr = 3'd4;
        idle(20);

        // R4 / R9: capture with tick held high every cycle
        set_pin(1'b1, p); exp_q.push_back(p - lastp - 1); lastp = p;
        idle(10);
        rd(3'd2, v); check(v, 0, "R6 no wrap");
        set_pin(1'b0, dummy); idle(15);               // R5 falling ignored in rise mode
        rd(3'd4, v); check(v, exp_cap_last(), "R5 capture unchanged");
        set_pin(1'b1, p); exp_q.push_back(p - lastp - 1); lastp = p;
        idle(12);

        // R8: running, only edge bits change
        wr(3'd1, 16'h0002, dummy);
        rd(3'd1, v); check(v, 6, "R8 mode write running");
        set_pin(1'b0, p); exp_q.push_back(p - lastp - 1); lastp = p;
        idle(9);
        set_pin(1'b1, p); exp_q.push_back(p - lastp - 1); lastp = p;
        idle(14);
        wr(3'd1, 16'h0000, dummy);
        rd(3'd1, v); check(v, 4, "R8 mode falling running");
        idle(5);
        set_pin(1'b0, p); exp_q.push_back(p - lastp - 1); lastp = p;
        idle(10);
        set_pin(1'b1, dummy); idle(10);               // R5 rising ignored in fall mode
        set_pin(1'b0, p); exp_q.push_back(p - lastp - 1); lastp = p;
        idle(10);

        // R7 stop
        wr(3'd0, 16'h0002, dummy);
        rd(3'd0, v); check(v, 0, "R7 stopped");
        rd(3'd3, c1);
        idle(20);
        set_pin(1'b1, dummy); idle(6);
        set_pin(1'b0, dummy); idle(6);
        rd(3'd3, v); check(v, c1, "R7 count held");
        rd(3'd2, v); check(v, 0, "R7 status held");

        // R6 / R3: wrap interval, start irq off
        wr(3'd1, 16'h0001, dummy);
        rd(3'd1, v); check(v, 1, "R3 start irq off");
        wr(3'd0, 16'h0001, n_w);
        lastp = n_w - 1;
        idle(70000);
        set_pin(1'b1, p); exp_q.push_back((p - lastp - 1) % 65536); lastp = p;
        idle(10);
        rd(3'd2, v); check(v, 1, "R6 wrap flagged");
        set_pin(1'b0, dummy); idle(20);
        set_pin(1'b1, p); exp_q.push_back(p - lastp - 1); lastp = p;
        idle(10);
        rd(3'd2, v); check(v, 0, "R6 flag rewritten");

        // R2: no tick, counter holds
        @(negedge clk); tick = 1'b0;
        rd(3'd3, c1); idle(15);
        rd(3'd3, v); check(v, c1, "R2 hold without tick");
        @(negedge clk); tick = 1'b1;
        idle(5);

        // R10: unit disable
        @(negedge clk); unit_en = 1'b0;
        idle(2);
        @(negedge clk); unit_en = 1'b1;
        rd(3'd0, v); check(v, 0, "R10 ctrl cleared");
        rd(3'd1, v); check(v, 0, "R10 mode cleared");
        rd(3'd3, v); check(v, 0, "R10 count cleared");
        rd(3'd4, v); check(v, 0, "R10 capture cleared");

        idle(5);
        check(exp_q.size(), 0, "R4 all expected irqs seen");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // last capture pushed: used to show an ignored edge left the capture intact
    int last_cap = 0;
    always @(posedge clk) begin
        #3;
        if (rst_n && irq && rd_addr == 3'd4) last_cap = int'(rd_data);
    end

    function automatic int exp_cap_last();
        return last_cap;
    endfunction
endmodule